// File: doc/BRIEF.md
# PLL Ratio Control and Lock Sequencer

This block is the digital control side of an on-chip clock multiplier. It holds two settings. The first is a 4-bit multiplier ratio: zero means the oscillator is passed straight through, and 1 to 10 is the multiply factor. The second is a 2-bit post-divider code, which sets how far the multiplied clock is divided before it reaches the system clock. After every accepted ratio write it counts a fixed number of oscillator cycles, then reports the loop as locked.

Software reaches the settings through a small register port. Writes land only while the protection gate is open. The block enforces the safe order of operations. The ratio can change only while the post-divider sits at its slowest code and the watchdog is off. The post-divider can change only once lock has been reached. Pass-through division (divide-by-1) is allowed only in bypass. A write that breaks a rule, or that asks for a reserved ratio, is dropped and raises a sticky error flag.

Hard reset and watchdog reset restore the defaults. A debugger reset leaves the clock settings alone and clears only the error flag.

Top module: `pll_ratio_seq`

## Requirements
- R1: A write to address 0 takes the ratio from wr_data[3:0]. Values 0 to 10 are accepted. Values 11 to 15 are reserved: the ratio is left unchanged and the error flag is set.
- R2: sys_shift_o gives log2 of the system-clock divide. It is 2 for divider codes 0 and 1, 1 for code 2, and 0 for code 3.
- R3: Hard reset (rst_n low) and a one-cycle watchdog reset (wdog_rst high) both set ratio 0, divider 0, lock 1 and error 0.
- R4: A ratio write is accepted only while the divider code is 0 and wdog_en is low. Otherwise it is ignored and sets the error flag.
- R5: On the clock edge that accepts a ratio write, lock drops to 0. It returns to 1 exactly LOCK_CYCLES clock edges later. Writing the same ratio again restarts the count.
- R6: A divider write to address 1 (code in wr_data[1:0]) is accepted only while lock is 1. Otherwise it is ignored and sets the error flag.
- R7: Divider code 3 is rejected, with the error flag set, while the ratio is nonzero.
- R8: While prot_open is low, every write is ignored and the error flag does not change.
- R9: The error flag is sticky. A write to address 2 with wr_data[0]=1 clears it.
- R10: A dbg_rst pulse clears the error flag and leaves the ratio, the divider and lock unchanged.
- R11: The read port returns the ratio at address 0. At address 1 it returns status: bits [1:0] divider, bit 2 lock, bit 3 error. Addresses 2 and 3 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Hard reset, asynchronous, active low |
| wdog_rst | input | 1 | Watchdog reset, synchronous, active high |
| dbg_rst | input | 1 | Debugger reset, synchronous, active high |
| wdog_en | input | 1 | Watchdog currently enabled |
| prot_open | input | 1 | Write protection lifted |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 4 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 4 | Read data (combinational) |
| ratio_o | output | 4 | Current multiplier ratio |
| div_sel_o | output | 2 | Current divider code |
| sys_shift_o | output | 2 | log2 of the system-clock divide |
| lock_o | output | 1 | Lock status |
| err_o | output | 1 | Sticky error flag |

## Verification
The sequencer is driven through several write patterns, each aimed at a different rule:
- Legal ratio and divider writes confirm the stored values and the divider decode for every code.
- Writes that each break exactly one rule show which condition blocked them. These are a reserved ratio, a set watchdog, a nonzero divider, a pending lock, and divide-by-1 with the multiplier active.
- A write with protection closed is checked separately from a rule break, since it must leave the error flag alone.
- The lock count is sampled on the cycle before and the cycle of its expected rise, and again after a same-value rewrite.
- The three reset inputs are told apart by which fields each one restores.

// File: rtl/pllc_pkg.sv
package pllc_pkg;
  localparam int RATIO_W = 4;
  localparam int DIV_W   = 2;
  localparam int ADDR_W  = 2;
  localparam int DATA_W  = RATIO_W;
  localparam logic [RATIO_W-1:0] RATIO_MAX = RATIO_W'(10);
  localparam logic [DIV_W-1:0]   DIV_BYP   = DIV_W'(3);

  typedef enum logic [ADDR_W-1:0] {
    A_RATIO  = 2'd0,
    A_STAT   = 2'd1,
    A_ERRCLR = 2'd2,
    A_SPARE  = 2'd3
  } addr_e;

  typedef struct packed {
    logic ratio_ok;
    logic div_ok;
    logic clr_err;
    logic violation;
  } wr_dec_t;

  function automatic logic [1:0] div_shift(input logic [DIV_W-1:0] code);
    case (code)
      2'd2:    return 2'd1;
      2'd3:    return 2'd0;
      default: return 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/pllc_rst_sync.sv
module pllc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/pllc_wr_check.sv
module pllc_wr_check
  import pllc_pkg::*;
(
  input  logic               wr_en,
  input  logic               prot_open,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [RATIO_W-1:0] ratio_q,
  input  logic [DIV_W-1:0]   div_q,
  input  logic               lock,
  input  logic               wdog_en,
  output wr_dec_t            dec
);
  logic             wr_go;
  logic             is_ratio;
  logic             is_div;
  logic [DIV_W-1:0] new_div;

  always_comb begin
    wr_go    = wr_en && prot_open;
    is_ratio = wr_go && (wr_addr == A_RATIO);
    is_div   = wr_go && (wr_addr == A_STAT);
    new_div  = wr_data[DIV_W-1:0];

    dec.ratio_ok  = is_ratio && (div_q == '0) && !wdog_en &&
                    (wr_data[RATIO_W-1:0] <= RATIO_MAX);
    dec.div_ok    = is_div && lock &&
                    !((new_div == DIV_BYP) && (ratio_q != '0));
    dec.clr_err   = wr_go && (wr_addr == A_ERRCLR) && wr_data[0];
    dec.violation = (is_ratio && !dec.ratio_ok) || (is_div && !dec.div_ok);
  end
endmodule

// File: rtl/pllc_lock_timer.sv
module pllc_lock_timer #(
  parameter int LOCK_CYCLES = 131072
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wdog_rst,
  input  logic start,
  output logic lock
);
  localparam int CNT_W = (LOCK_CYCLES > 2) ? $clog2(LOCK_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(LOCK_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             lock_q, lock_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    lock_d = lock_q;
    cnt_en = wdog_rst || start || !lock_q;
    if (wdog_rst) begin
      cnt_d  = '0;
      lock_d = 1'b1;
    end else if (start) begin
      cnt_d  = LOAD;
      lock_d = 1'b0;
    end else if (!lock_q) begin
      if (cnt_q == '0) lock_d = 1'b1;
      else             cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lock_q <= 1'b1;
    end else if (cnt_en) begin
      cnt_q  <= cnt_d;
      lock_q <= lock_d;
    end
  end

  assign lock = lock_q;

  a_r5_start_clears_lock: assert property (@(posedge clk) disable iff (!rst_n)
    start && !wdog_rst |=> !lock_q);
  a_r5_no_rise_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> $past(wdog_rst) || !$past(start));
  a_r3_wdog_sets_lock: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_rst |=> lock_q);
endmodule

// File: rtl/pll_ratio_seq.sv
module pll_ratio_seq
  import pllc_pkg::*;
#(
  parameter int LOCK_CYCLES = 131072,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wdog_rst,
  input  logic               dbg_rst,
  input  logic               wdog_en,
  input  logic               prot_open,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [DATA_W-1:0]  rd_data,
  output logic [RATIO_W-1:0] ratio_o,
  output logic [DIV_W-1:0]   div_sel_o,
  output logic [1:0]         sys_shift_o,
  output logic               lock_o,
  output logic               err_o
);
  logic               rst_sync_n;
  logic [RATIO_W-1:0] ratio_q, ratio_d;
  logic [DIV_W-1:0]   div_q, div_d;
  logic               err_q, err_d;
  logic               reg_en;
  logic               lock;
  wr_dec_t            dec;

  pllc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  pllc_wr_check u_chk (
    .wr_en(wr_en), .prot_open(prot_open), .wr_addr(wr_addr), .wr_data(wr_data),
    .ratio_q(ratio_q), .div_q(div_q), .lock(lock), .wdog_en(wdog_en), .dec(dec)
  );

  pllc_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .clk(clk), .rst_n(rst_sync_n), .wdog_rst(wdog_rst),
    .start(dec.ratio_ok), .lock(lock)
  );

  always_comb begin
    ratio_d = ratio_q;
    div_d   = div_q;
    err_d   = err_q;
    reg_en  = wdog_rst || dbg_rst || dec.ratio_ok || dec.div_ok ||
              dec.violation || dec.clr_err;
    if (wdog_rst) begin
      ratio_d = '0;
      div_d   = '0;
      err_d   = 1'b0;
    end else begin
      if (dec.ratio_ok) ratio_d = wr_data[RATIO_W-1:0];
      if (dec.div_ok)   div_d   = wr_data[DIV_W-1:0];
      if (dbg_rst)             err_d = 1'b0;
      else if (dec.violation)  err_d = 1'b1;
      else if (dec.clr_err)    err_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ratio_q <= '0;
      div_q   <= '0;
      err_q   <= 1'b0;
    end else if (reg_en) begin
      ratio_q <= ratio_d;
      div_q   <= div_d;
      err_q   <= err_d;
    end
  end

  always_comb begin
    case (rd_addr)
      A_RATIO: rd_data = DATA_W'(ratio_q);
      A_STAT:  rd_data = DATA_W'({err_q, lock, div_q});
      default: rd_data = '0;
    endcase
  end

  assign ratio_o     = ratio_q;
  assign div_sel_o   = div_q;
  assign sys_shift_o = div_shift(div_q);
  assign lock_o      = lock;
  assign err_o       = err_q;

  a_r1_ratio_range: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ratio_q <= RATIO_MAX);
  a_r7_div3_only_bypass: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (div_q == DIV_BYP) |-> (ratio_q == '0));
  a_r6_div_change_needs_lock: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (div_q != $past(div_q)) |-> ($past(lock) || $past(wdog_rst)));
  a_r4_ratio_change_needs_div0: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ratio_q != $past(ratio_q)) |-> (($past(div_q) == '0) || $past(wdog_rst)));
  a_r8_closed_gate_holds: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(!prot_open) && $past(!wdog_rst) && $past(!dbg_rst) |->
      $stable(ratio_q) && $stable(div_q) && $stable(err_q));
  a_r10_dbg_keeps_setup: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(dbg_rst) && $past(!wdog_rst) && $past(!wr_en) |->
      $stable(ratio_q) && $stable(div_q) && !err_q);
endmodule

// File: tb/tb_pll_ratio_seq.sv
module tb_pll_ratio_seq;
  localparam int LK = 40;

  logic       clk = 1'b0;
  logic       rst_n, wdog_rst, dbg_rst, wdog_en, prot_open, wr_en;
  logic [1:0] wr_addr, rd_addr;
  logic [3:0] wr_data, rd_data, ratio_o;
  logic [1:0] div_sel_o, sys_shift_o;
  logic       lock_o, err_o;

  int total = 0;
  int bad   = 0;
  bit busy  = 1'b0;

  typedef struct {
    string      req;
    int         sel;
    logic [3:0] exp;
  } item_t;
  item_t q[$];

  always #2.5 clk = ~clk;

  pll_ratio_seq #(.LOCK_CYCLES(LK)) dut (
    .clk(clk), .rst_n(rst_n), .wdog_rst(wdog_rst), .dbg_rst(dbg_rst),
    .wdog_en(wdog_en), .prot_open(prot_open), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .ratio_o(ratio_o), .div_sel_o(div_sel_o), .sys_shift_o(sys_shift_o),
    .lock_o(lock_o), .err_o(err_o)
  );

  task automatic cmp(input string req, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // monitor: sel 0 read ratio, 1 read status, 2 sys_shift_o, 3 lock_o, 4 ratio_o, 5 read addr 2
  initial begin
    item_t it;
    logic [3:0] act;
    forever begin
      wait (q.size() != 0);
      @(negedge clk);
      it = q.pop_front();
      busy = 1'b1;
      case (it.sel)
        0: rd_addr = 2'd0;
        1: rd_addr = 2'd1;
        5: rd_addr = 2'd2;
        default: rd_addr = 2'd0;
      endcase
      #1;
      case (it.sel)
        2: act = {2'b00, sys_shift_o};
        3: act = {3'b000, lock_o};
        4: act = ratio_o;
        default: act = rd_data;
      endcase
      cmp(it.req, act, it.exp);
      busy = 1'b0;
    end
  end

  task automatic expect_q(input string req, input int sel, input logic [3:0] e);
    q.push_back('{req, sel, e});
    wait (q.size() == 0 && !busy);
  endtask

  task automatic wr(input logic [1:0] a, input logic [3:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_wdog();
    @(negedge clk); wdog_rst = 1'b1;
    @(negedge clk); wdog_rst = 1'b0;
  endtask

  task automatic pulse_dbg();
    @(negedge clk); dbg_rst = 1'b1;
    @(negedge clk); dbg_rst = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wdog_rst = 1'b0; dbg_rst = 1'b0; wdog_en = 1'b0;
    prot_open = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R3 / R11 reset state
    expect_q("R3 ratio after hard reset", 0, 4'h0);
    expect_q("R3 status after hard reset", 1, 4'h4);
    expect_q("R2 shift at code 0", 2, 4'd2);
    expect_q("R11 addr 2 reads zero", 5, 4'h0);

    // R1 legal max ratio, then reserved value
    wr(2'd0, 4'd10);
    expect_q("R1 ratio 10 accepted", 0, 4'd10);
    repeat (LK + 5) @(negedge clk);
    wr(2'd0, 4'd11);
    expect_q("R1 reserved ratio ignored", 4, 4'd10);
    expect_q("R1 reserved ratio sets error", 1, 4'hC);
    wr(2'd2, 4'h1);
    expect_q("R9 error cleared", 1, 4'h4);

    // back to bypass, divider decode for every code
    wr(2'd0, 4'd0);
    repeat (LK + 5) @(negedge clk);
    wr(2'd1, 4'd3);
    expect_q("R7 code 3 legal in bypass", 1, 4'h7);
    expect_q("R2 shift at code 3", 2, 4'd0);
    wr(2'd1, 4'd2);
    expect_q("R2 shift at code 2", 2, 4'd1);
    wr(2'd1, 4'd1);
    expect_q("R2 shift at code 1", 2, 4'd2);

    // R4 ratio write with divider nonzero
    wr(2'd0, 4'd5);
    expect_q("R4 ratio blocked by divider", 0, 4'd0);
    expect_q("R4 error set by divider rule", 1, 4'hD);
    wr(2'd2, 4'h1);
    wr(2'd1, 4'd0);
    expect_q("R6 divider 0 restored", 1, 4'h4);

    // R8 protection closed
    prot_open = 1'b0;
    wr(2'd0, 4'd5);
    expect_q("R8 closed gate keeps ratio", 0, 4'd0);
    expect_q("R8 closed gate no error", 1, 4'h4);
    prot_open = 1'b1;

    // R4 watchdog enabled
    wdog_en = 1'b1;
    wr(2'd0, 4'd5);
    expect_q("R4 ratio blocked by watchdog", 0, 4'd0);
    expect_q("R4 watchdog rule sets error", 1, 4'hC);
    wdog_en = 1'b0;
    wr(2'd2, 4'h1);

    // R5 lock boundary
    wr(2'd0, 4'd7);
    cmp("R5 lock clears on accept", {3'b0, lock_o}, 4'd0);
    repeat (LK - 1) @(negedge clk);
    cmp("R5 lock still low one cycle early", {3'b0, lock_o}, 4'd0);
    @(negedge clk);
    cmp("R5 lock high after count", {3'b0, lock_o}, 4'd1);
    expect_q("R1 ratio 7 stored", 0, 4'd7);

    // R5 rewrite same ratio restarts; R6 divider during pending lock
    wr(2'd0, 4'd7);
    cmp("R5 same-value rewrite clears lock", {3'b0, lock_o}, 4'd0);
    wr(2'd1, 4'd2);
    expect_q("R6 divider blocked while unlocked", 1, 4'h8);
    repeat (LK + 5) @(negedge clk);
    expect_q("R5 relocked", 3, 4'd1);
    wr(2'd2, 4'h1);
    wr(2'd1, 4'd3);
    expect_q("R7 code 3 rejected with ratio 7", 1, 4'hC);
    wr(2'd2, 4'h1);
    wr(2'd1, 4'd2);
    expect_q("R6 divider accepted when locked", 1, 4'h6);
    expect_q("R2 shift with code 2", 2, 4'd1);

    // R10 debugger reset
    wr(2'd0, 4'd3);
    expect_q("R9 error sticky after reject", 1, 4'hE);
    pulse_dbg();
    expect_q("R10 dbg keeps ratio", 0, 4'd7);
    expect_q("R10 dbg clears only error", 1, 4'h6);

    // R3 watchdog reset
    pulse_wdog();
    expect_q("R3 watchdog reset ratio", 4, 4'd0);
    expect_q("R3 watchdog reset status", 1, 4'h4);
    expect_q("R3 watchdog reset shift", 2, 4'd2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule